// File: doc/BRIEF.md
# Serial Programming Command Target

This block is the device-side end of a three-wire in-system programming link. An external programmer drives a serial clock and a data line; the block runs entirely on the device CPU clock, brings both wires into that domain through a two-flop synchronizer and finds the edges of the serial clock there. It takes data bits on rising edges and moves its own response bit on falling edges. It groups the bits into bytes and the bytes into four-byte instructions.

The first instruction must be a programming-enable. While the third byte of that instruction is shifted in, the block returns the enable's second byte (0x53). A programmer uses that echo to confirm that its byte boundaries match the block's. Once enabled, the block turns read, write and chip-erase instructions into requests on a simple memory port. That port addresses the program array or the EEPROM array, and it has a one-cycle erase strobe for the storage behind it. A write to EEPROM needs no erase before it, because the storage erases the cell itself as part of the write.

Top module: `isp_target`

## Requirements
- R1: `isp_sck` and `isp_sdi` pass through a two-flop synchronizer. When every serial clock high and low level lasts at least 3 CPU clock cycles, each serial clock edge is detected exactly once.
- R2: Data on `isp_sdi` is taken at each detected rising edge of the serial clock, most significant bit first. Eight bits form one byte.
- R3: `isp_sdo` changes only after a detected falling edge of the serial clock. The response byte's most significant bit is on `isp_sdo` before the first rising edge of that byte.
- R4: Bytes are grouped four to an instruction. The byte position returns to 0 after the fourth byte.
- R5: While `isp_active` is low, the byte and bit positions are held at 0, the enabled state is cleared, no memory request or erase is issued, and `isp_sdo` is 0. At reset, `isp_sdo`, `mem_req` and `erase_req` are 0.
- R6: The instruction 0xAC, 0x53, x, x enables the block when its fourth byte completes. During its third byte, `isp_sdo` returns 0x53.
- R7: Until the block is enabled, no instruction other than programming-enable has any effect on `mem_req` or `erase_req`.
- R8: When enabled, the instruction 0xAC, 0x80, x, x raises `erase_req` for exactly one cycle after its fourth byte completes.
- R9: When enabled, the instruction 0x20 (program) or 0xA0 (EEPROM), A_hi, A_lo, x issues a one-cycle read request after the third byte completes. The request has `mem_we`=0, address {A_hi, A_lo}, and `mem_eeprom`=1 for 0xA0. The value of `mem_rdata` in that cycle is the response during the fourth byte.
- R10: When enabled, the instruction 0x40 (program) or 0xC0 (EEPROM), A_hi, A_lo, D issues a one-cycle write request after the fourth byte completes. The request has `mem_we`=1, address {A_hi, A_lo} and `mem_wdata`=D, and it raises no erase.
- R11: Apart from the read response, each response byte is the byte received just before it. The response is 0x00 for the first byte after reset or after `isp_active` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| isp_active | input | 1 | High while the device is held in programming mode |
| isp_sck | input | 1 | Serial clock from the programmer (asynchronous) |
| isp_sdi | input | 1 | Serial data from the programmer |
| isp_sdo | output | 1 | Serial response data to the programmer |
| mem_req | output | 1 | One-cycle memory access strobe |
| mem_we | output | 1 | 1 = write, 0 = read, valid with `mem_req` |
| mem_eeprom | output | 1 | 1 = EEPROM array, 0 = program array |
| mem_addr | output | 16 | Byte address of the access |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the `mem_req` cycle |
| erase_req | output | 1 | One-cycle chip-erase strobe |

## Verification
The assertions assume that each serial clock level lasts at least three CPU cycles. They also assume that `isp_sdi` does not change near a rising serial edge and that `mem_rdata` answers within the request cycle. Together these leave room between a detected rising edge and the next falling edge for the read data to arrive. The stimulus changes data only at the start of a low phase. It holds each phase for exactly three CPU cycles, the tightest legal case, and then for five. It computes read data with a fixed function of the request's array and address.

// File: rtl/isp_pkg.sv
package isp_pkg;

  localparam int CMD_BYTE_W = 8;
  localparam int CMD_BYTES  = 4;

  localparam logic [7:0] OP_ENABLE_HI = 8'hAC;
  localparam logic [7:0] OP_ENABLE_LO = 8'h53;
  localparam logic [7:0] OP_ERASE_LO  = 8'h80;
  localparam logic [7:0] OP_RD_PROG   = 8'h20;
  localparam logic [7:0] OP_RD_EE     = 8'hA0;
  localparam logic [7:0] OP_WR_PROG   = 8'h40;
  localparam logic [7:0] OP_WR_EE     = 8'hC0;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_ENABLE,
    CMD_ERASE,
    CMD_RD_PROG,
    CMD_RD_EE,
    CMD_WR_PROG,
    CMD_WR_EE
  } cmd_e;

  // Decode an instruction from its first two bytes.
  function automatic cmd_e classify(input logic [7:0] op, input logic [7:0] arg);
    cmd_e k;
    k = CMD_NONE;
    if (op == OP_ENABLE_HI) begin
      if (arg == OP_ENABLE_LO)     k = CMD_ENABLE;
      else if (arg == OP_ERASE_LO) k = CMD_ERASE;
    end
    else if (op == OP_RD_PROG) k = CMD_RD_PROG;
    else if (op == OP_RD_EE)   k = CMD_RD_EE;
    else if (op == OP_WR_PROG) k = CMD_WR_PROG;
    else if (op == OP_WR_EE)   k = CMD_WR_EE;
    return k;
  endfunction

  function automatic logic is_read(input cmd_e k);
    return (k == CMD_RD_PROG) || (k == CMD_RD_EE);
  endfunction

  function automatic logic is_write(input cmd_e k);
    return (k == CMD_WR_PROG) || (k == CMD_WR_EE);
  endfunction

  function automatic logic targets_eeprom(input cmd_e k);
    return (k == CMD_RD_EE) || (k == CMD_WR_EE);
  endfunction

endpackage

// File: rtl/isp_edge_sync.sv
module isp_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic sdi_i,
  output logic rise_o,
  output logic fall_o,
  output logic sdi_o
);

  logic [STAGES-1:0] sck_pipe;
  logic [STAGES-1:0] sdi_pipe;
  logic              sck_last;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sck_pipe <= '0;
          sdi_pipe <= '0;
        end else begin
          sck_pipe <= sck_i;
          sdi_pipe <= sdi_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sck_pipe <= '0;
          sdi_pipe <= '0;
        end else begin
          sck_pipe <= {sck_pipe[STAGES-2:0], sck_i};
          sdi_pipe <= {sdi_pipe[STAGES-2:0], sdi_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_last <= 1'b0;
    else        sck_last <= sck_pipe[STAGES-1];
  end

  assign rise_o = sck_pipe[STAGES-1] & ~sck_last;
  assign fall_o = ~sck_pipe[STAGES-1] & sck_last;
  assign sdi_o  = sdi_pipe[STAGES-1];

  // R1: with levels of at least 3 cycles, edges are never adjacent
  p_edge_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o || fall_o) |=> !(rise_o || fall_o));

endmodule

// File: rtl/isp_shift_engine.sv
module isp_shift_engine #(
  parameter int BYTE_W = 8,
  parameter int BYTES  = 4,
  localparam int BITW  = $clog2(BYTE_W),
  localparam int IDXW  = $clog2(BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sdi_i,
  input  logic [BYTE_W-1:0] tx_next_i,
  output logic              byte_valid_o,
  output logic [IDXW-1:0]   byte_num_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              sdo_o
);

  localparam logic [BITW-1:0] LAST_BIT  = BITW'(BYTE_W - 1);
  localparam logic [IDXW-1:0] LAST_BYTE = IDXW'(BYTES - 1);

  logic [BITW-1:0]   bit_cnt;
  logic [IDXW-1:0]   byte_idx;
  logic [BYTE_W-1:0] rx_sr;
  logic [BYTE_W-1:0] tx_sr;
  logic              load_pend;
  logic [BYTE_W-1:0] rx_next;
  logic              last_bit;

  assign rx_next  = {rx_sr[BYTE_W-2:0], sdi_i};
  assign last_bit = (bit_cnt == LAST_BIT);
  assign sdo_o    = tx_sr[BYTE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt      <= '0;
      byte_idx     <= '0;
      rx_sr        <= '0;
      tx_sr        <= '0;
      load_pend    <= 1'b0;
      byte_valid_o <= 1'b0;
      byte_num_o   <= '0;
      byte_o       <= '0;
    end else begin
      byte_valid_o <= 1'b0;
      if (!active_i) begin
        bit_cnt   <= '0;
        byte_idx  <= '0;
        tx_sr     <= '0;
        load_pend <= 1'b0;
      end else begin
        if (rise_i) begin
          rx_sr <= rx_next;
          if (last_bit) begin
            bit_cnt      <= '0;
            byte_valid_o <= 1'b1;
            byte_o       <= rx_next;
            byte_num_o   <= byte_idx;
            byte_idx     <= (byte_idx == LAST_BYTE) ? '0 : IDXW'(byte_idx + 1'b1);
            load_pend    <= 1'b1;
          end else begin
            bit_cnt <= BITW'(bit_cnt + 1'b1);
          end
        end
        if (fall_i) begin
          if (load_pend) begin
            tx_sr     <= tx_next_i;
            load_pend <= 1'b0;
          end else begin
            tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  // R4: the position wraps to zero once the last byte of a frame is in
  p_frame_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid_o && byte_num_o == LAST_BYTE) |-> byte_idx == '0);

  // R3: the response line moves only after a detected falling edge
  p_sdo_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && !fall_i) |=> (!active_i || $stable(sdo_o)));

  // R5: an inactive link keeps the response line low
  p_idle_sdo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> !sdo_o);

endmodule

// File: rtl/isp_cmd_decoder.sv
module isp_cmd_decoder
  import isp_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int BYTES  = 4,
  localparam int IDXW  = $clog2(BYTES),
  localparam int ADDR_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_i,
  input  logic              byte_valid_i,
  input  logic [IDXW-1:0]   byte_num_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic [BYTE_W-1:0] tx_next_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mem_eeprom_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic              erase_o
);

  logic [BYTE_W-1:0] op_q;
  logic [BYTE_W-1:0] arg_q;
  logic [BYTE_W-1:0] lo_q;
  logic              unlocked_q;
  cmd_e              kind;
  logic              at_addr_end;
  logic              at_frame_end;

  assign kind         = classify(8'(op_q), 8'(arg_q));
  assign at_addr_end  = byte_valid_i && (byte_num_i == IDXW'(2));
  assign at_frame_end = byte_valid_i && (byte_num_i == IDXW'(BYTES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q         <= '0;
      arg_q        <= '0;
      lo_q         <= '0;
      unlocked_q   <= 1'b0;
      tx_next_o    <= '0;
      mem_req_o    <= 1'b0;
      mem_we_o     <= 1'b0;
      mem_eeprom_o <= 1'b0;
      mem_addr_o   <= '0;
      mem_wdata_o  <= '0;
      erase_o      <= 1'b0;
    end else begin
      mem_req_o <= 1'b0;
      erase_o   <= 1'b0;
      if (!active_i) begin
        unlocked_q <= 1'b0;
        tx_next_o  <= '0;
      end else begin
        if (mem_req_o && !mem_we_o) tx_next_o <= mem_rdata_i;
        if (byte_valid_i) begin
          tx_next_o <= byte_i;
          if (byte_num_i == IDXW'(0)) op_q  <= byte_i;
          if (byte_num_i == IDXW'(1)) arg_q <= byte_i;
          if (at_addr_end) begin
            lo_q <= byte_i;
            if (unlocked_q && is_read(kind)) begin
              mem_req_o    <= 1'b1;
              mem_we_o     <= 1'b0;
              mem_eeprom_o <= targets_eeprom(kind);
              mem_addr_o   <= {arg_q, byte_i};
            end
          end
          if (at_frame_end) begin
            if (kind == CMD_ENABLE) unlocked_q <= 1'b1;
            if (unlocked_q && kind == CMD_ERASE) erase_o <= 1'b1;
            if (unlocked_q && is_write(kind)) begin
              mem_req_o    <= 1'b1;
              mem_we_o     <= 1'b1;
              mem_eeprom_o <= targets_eeprom(kind);
              mem_addr_o   <= {arg_q, lo_q};
              mem_wdata_o  <= byte_i;
            end
          end
        end
      end
    end
  end

  // R7: nothing reaches the memory port before the link is enabled
  p_locked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked_q |-> (!mem_req_o && !erase_o));

  // R8: erase is a single-cycle strobe and never overlaps an access
  p_erase_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    erase_o |=> !erase_o);
  p_one_action_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req_o, erase_o}));

  // R9: a read follows the completion of the third byte
  p_read_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_we_o) |-> $past(at_addr_end));

  // R10: a write follows the completion of the fourth byte
  p_write_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o) |-> $past(at_frame_end));

endmodule

// File: rtl/isp_target.sv
module isp_target
  import isp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = CMD_BYTE_W,
  parameter int BYTES       = CMD_BYTES,
  localparam int ADDR_W     = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              isp_active,
  input  logic              isp_sck,
  input  logic              isp_sdi,
  output logic              isp_sdo,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_eeprom,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              erase_req
);

  localparam int IDXW = $clog2(BYTES);

  logic              sck_rise;
  logic              sck_fall;
  logic              sdi_sync;
  logic              byte_valid;
  logic [IDXW-1:0]   byte_num;
  logic [BYTE_W-1:0] byte_val;
  logic [BYTE_W-1:0] tx_next;

  isp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .sck_i  (isp_sck),
    .sdi_i  (isp_sdi),
    .rise_o (sck_rise),
    .fall_o (sck_fall),
    .sdi_o  (sdi_sync)
  );

  isp_shift_engine #(.BYTE_W(BYTE_W), .BYTES(BYTES)) u_shift (
    .clk          (clk),
    .rst_n        (rst_n),
    .active_i     (isp_active),
    .rise_i       (sck_rise),
    .fall_i       (sck_fall),
    .sdi_i        (sdi_sync),
    .tx_next_i    (tx_next),
    .byte_valid_o (byte_valid),
    .byte_num_o   (byte_num),
    .byte_o       (byte_val),
    .sdo_o        (isp_sdo)
  );

  isp_cmd_decoder #(.BYTE_W(BYTE_W), .BYTES(BYTES)) u_dec (
    .clk          (clk),
    .rst_n        (rst_n),
    .active_i     (isp_active),
    .byte_valid_i (byte_valid),
    .byte_num_i   (byte_num),
    .byte_i       (byte_val),
    .mem_rdata_i  (mem_rdata),
    .tx_next_o    (tx_next),
    .mem_req_o    (mem_req),
    .mem_we_o     (mem_we),
    .mem_eeprom_o (mem_eeprom),
    .mem_addr_o   (mem_addr),
    .mem_wdata_o  (mem_wdata),
    .erase_o      (erase_req)
  );

  // R5: an inactive link issues no memory traffic on the following cycle
  p_idle_port_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !isp_active |=> (!mem_req && !erase_req));

endmodule

// File: tb/isp_target_tb_top.sv
module isp_target_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        isp_active = 1'b0;
  logic        isp_sck = 1'b0;
  logic        isp_sdi = 1'b0;
  logic        isp_sdo;
  logic        mem_req;
  logic        mem_we;
  logic        mem_eeprom;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic        erase_req;

  always #10 clk = ~clk;

  isp_target dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .isp_active (isp_active),
    .isp_sck    (isp_sck),
    .isp_sdi    (isp_sdi),
    .isp_sdo    (isp_sdo),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_eeprom (mem_eeprom),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .erase_req  (erase_req)
  );

  typedef struct packed {
    logic        we;
    logic        ee;
    logic [15:0] addr;
    logic [7:0]  data;
  } ev_t;

  int   n_checks = 0;
  int   n_err    = 0;
  int   ph       = 3;
  bit   done     = 0;
  ev_t  exp_q[$];
  int   exp_erase = 0;
  int   obs_erase = 0;
  logic [7:0] last_rx = 8'h00;
  bit   unlocked = 0;

  function automatic logic [7:0] mem_fn(input logic ee, input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ (ee ? 8'hC3 : 8'h3C);
  endfunction

  assign mem_rdata = mem_fn(mem_eeprom, mem_addr);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison of the memory port against the expected queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (erase_req) obs_erase++;
      if (mem_req) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 unexpected mem_req", {mem_we, mem_eeprom, mem_addr}, 0);
        end else begin
          ev_t e;
          e = exp_q.pop_front();
          chk(mem_we == e.we && mem_eeprom == e.ee && mem_addr == e.addr,
              e.we ? "R10 write request" : "R9 read request",
              {mem_we, mem_eeprom, mem_addr}, {e.we, e.ee, e.addr});
          if (e.we) chk(mem_wdata == e.data, "R10 write data", mem_wdata, e.data);
        end
      end
    end
  end

  task automatic send_byte(input logic [7:0] b, input logic [7:0] exp, input string req);
    for (int i = 7; i >= 0; i--) begin
      isp_sdi = b[i];
      repeat (ph) @(negedge clk);
      chk(isp_sdo === exp[i], req, isp_sdo, exp[i]);
      isp_sck = 1'b1;
      repeat (ph) @(negedge clk);
      isp_sck = 1'b0;
    end
  endtask

  task automatic send_frame(input logic [7:0] b0, input logic [7:0] b1,
                            input logic [7:0] b2, input logic [7:0] b3);
    logic rd, wr, ee;
    logic [7:0] r3;
    ev_t e;
    rd = unlocked && (b0 == 8'h20 || b0 == 8'hA0);
    wr = unlocked && (b0 == 8'h40 || b0 == 8'hC0);
    ee = (b0 == 8'hA0 || b0 == 8'hC0);
    send_byte(b0, last_rx, "R2/R11 byte0");
    send_byte(b1, b0, "R4/R11 byte1");
    if (rd) begin
      e.we = 1'b0; e.ee = ee; e.addr = {b1, b2}; e.data = 8'h00;
      exp_q.push_back(e);
    end
    send_byte(b2, b1, (b0 == 8'hAC && b1 == 8'h53) ? "R6 echo" : "R11 byte2");
    r3 = rd ? mem_fn(ee, {b1, b2}) : b2;
    if (wr) begin
      e.we = 1'b1; e.ee = ee; e.addr = {b1, b2}; e.data = b3;
      exp_q.push_back(e);
    end
    send_byte(b3, r3, rd ? "R9 read data" : "R3/R11 byte3");
    last_rx = b3;
    if (unlocked && b0 == 8'hAC && b1 == 8'h80) exp_erase++;
    if (b0 == 8'hAC && b1 == 8'h53) unlocked = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(isp_sdo === 1'b0, "R5 reset sdo", isp_sdo, 0);
    chk(mem_req === 1'b0, "R5 reset mem_req", mem_req, 0);
    chk(erase_req === 1'b0, "R5 reset erase", erase_req, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    isp_active = 1'b1;
    repeat (4) @(negedge clk);

    // R7: locked instructions leave the port idle
    send_frame(8'h20, 8'h01, 8'h02, 8'h00);
    send_frame(8'hC0, 8'h00, 8'h10, 8'h55);
    send_frame(8'hAC, 8'h80, 8'h00, 8'h00);
    chk(obs_erase == 0, "R7 erase while locked", obs_erase, 0);

    // R6: enable with echo at the tightest phase length (R1)
    send_frame(8'hAC, 8'h53, 8'h00, 8'h00);
    send_frame(8'h20, 8'h12, 8'h34, 8'h00);
    send_frame(8'hA0, 8'hAB, 8'hCD, 8'hFF);
    send_frame(8'h40, 8'h00, 8'h10, 8'h5A);
    send_frame(8'hC0, 8'h01, 8'hFF, 8'h77);
    chk(obs_erase == 0, "R10 no erase on EEPROM write", obs_erase, 0);
    send_frame(8'hAC, 8'h80, 8'h11, 8'h22);
    chk(obs_erase == 1, "R8 erase pulse", obs_erase, 1);

    // R1: longer phases behave the same
    ph = 5;
    send_frame(8'h20, 8'hF0, 8'h0F, 8'h99);
    send_frame(8'h40, 8'h7E, 8'h81, 8'hA5);
    ph = 3;

    // R5: drop the link in the middle of a byte
    for (int i = 0; i < 3; i++) begin
      isp_sdi = i[0];
      repeat (ph) @(negedge clk);
      isp_sck = 1'b1;
      repeat (ph) @(negedge clk);
      isp_sck = 1'b0;
    end
    isp_active = 1'b0;
    repeat (2) @(negedge clk);
    chk(isp_sdo === 1'b0, "R5 inactive sdo", isp_sdo, 0);
    repeat (4) @(negedge clk);
    isp_active = 1'b1;
    last_rx = 8'h00;
    unlocked = 0;
    repeat (4) @(negedge clk);
    send_frame(8'hA0, 8'h00, 8'h01, 8'h00);
    send_frame(8'hAC, 8'h53, 8'h5E, 8'hE5);
    send_frame(8'hA0, 8'h00, 8'h01, 8'h00);
    send_frame(8'hAC, 8'h80, 8'h00, 8'h00);

    repeat (10) @(negedge clk);
    chk(obs_erase == exp_erase, "R8 erase count", obs_erase, exp_erase);
    chk(exp_q.size() == 0, "R9/R10 all requests seen", exp_q.size(), 0);
    done = 1;
    finish_run();
  end

endmodule